// File: doc/BRIEF.md
# Four-Channel Pixel Blend Unit

This block mixes two packed 32-bit pixels, each made of four 8-bit colour channels (alpha, red, green and blue), into one output pixel. Every channel has its own 8-bit weight, and the block handles all four channels side by side. Each weight picks how much of the first pixel appears in the result, and the second pixel fills the rest. A weight of 255 returns the first pixel unchanged, and a weight of 0 returns the second pixel unchanged.

The unit is a three-stage pipeline and takes one pixel pair per cycle. The first stage moves every channel into a 16-bit lane. It turns each weight f into f + (f >> 7), which lies between 0 and 256, and it also forms the complement, 256 minus that value. The second stage forms the two products in each lane and keeps the low 16 bits of each. The third stage adds the products, shifts the sum right by 8, clamps the result to a byte and packs the four bytes back into a word. A valid flag travels through the pipeline next to the data.

Top module: `pix_blend_top`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` is 0 and `out_pix` is 0 until the first result arrives.
- R2: A pair presented with `in_valid` high appears on the output exactly 3 clock cycles later, with `out_valid` high. Pairs may arrive every cycle or with gaps, and `out_valid` follows the `in_valid` pattern, delayed by 3 cycles.
- R3: Each 8-bit weight f is expanded to e = f + (f >> 7). So 0x7F gives 127, 0x80 gives 129, and 0xFF gives 256.
- R4: Channel i sits in bits [8i+7:8i] of each word. Blue is channel 0 and alpha is channel 3. Each output channel is (a·e + b·(256−e)) >> 8, worked out with the channel's own weight and independently of the other channels.
- R5: A weight of 0xFF in a channel makes that output channel equal to the channel of `in_pix_a`.
- R6: A weight of 0x00 in a channel makes that output channel equal to the channel of `in_pix_b`.
- R7: Each lane sum fits in 16 bits. The result is narrowed to a byte with unsigned saturation, so it never exceeds 255, and full-scale inputs give 255.
- R8: While `in_valid` is low, the data inputs are ignored. `out_pix` holds the last result and `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Qualifies the input pair and the weights |
| in_pix_a | input | 32 | First pixel, four 8-bit channels, alpha in the top byte |
| in_pix_b | input | 32 | Second pixel, same packing |
| in_factor | input | 32 | Per-channel 8-bit weights for `in_pix_a`, same packing |
| out_valid | output | 1 | High when `out_pix` holds a new result |
| out_pix | output | 32 | Blended pixel, same packing |

## Verification
The bench uses a different weight pattern to separate each possible fault:
- Weights of all ones and all zeros show whether the endpoints pass a pixel through exactly. They separate a correct expansion to 256 from a plain 0–255 scale, which would lose one step.
- Weights of 0x7F and 0x80 sit on either side of the step in the expansion, so they expose a wrong shift amount in the weight term.
- Words with a different weight in each channel, and seeded random words, detect lanes that are swapped, shared or cross-wired.
- Full-scale pixels exercise the clamp.
- Gapped valid patterns, and idle cycles with changing data, check the latency, the valid flag and that the output holds.

// File: rtl/pix_blend_pkg.sv
package pix_blend_pkg;
  localparam int PB_LANES = 4;
  localparam int PB_CH_W  = 8;
endpackage

// File: rtl/blend_expand.sv
module blend_expand
  import pix_blend_pkg::*;
#(
  parameter int LANES = PB_LANES,
  parameter int CH_W  = PB_CH_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [LANES*CH_W-1:0]    pix_a,
  input  logic [LANES*CH_W-1:0]    pix_b,
  input  logic [LANES*CH_W-1:0]    factor,
  output logic                     v_q,
  output logic [LANES*2*CH_W-1:0]  a_q,
  output logic [LANES*2*CH_W-1:0]  b_q,
  output logic [LANES*2*CH_W-1:0]  fa_q,
  output logic [LANES*2*CH_W-1:0]  fb_q
);
  localparam int LW = 2 * CH_W;
  localparam logic [LW-1:0] ONE = LW'(1) << CH_W;
  localparam logic [CH_W-1:0] FMAX = '1;

  logic [LANES*LW-1:0] a_d, b_d, fa_d, fb_d;
  logic                en;

  assign en = in_valid;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LW-1:0] f_w;
    logic [LW-1:0] fe;
    assign f_w = {{(LW-CH_W){1'b0}}, factor[i*CH_W +: CH_W]};
    assign fe  = f_w + (f_w >> (CH_W-1));

    always_comb begin
      a_d[i*LW +: LW]  = {{(LW-CH_W){1'b0}}, pix_a[i*CH_W +: CH_W]};
      b_d[i*LW +: LW]  = {{(LW-CH_W){1'b0}}, pix_b[i*CH_W +: CH_W]};
      fa_d[i*LW +: LW] = fe;
      fb_d[i*LW +: LW] = ONE - fe;
    end

    // R5
    fac_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && factor[i*CH_W +: CH_W] == FMAX) |=>
        (fa_q[i*LW +: LW] == ONE && fb_q[i*LW +: LW] == '0));

    // R6
    fac_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && factor[i*CH_W +: CH_W] == '0) |=>
        (fa_q[i*LW +: LW] == '0 && fb_q[i*LW +: LW] == ONE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      a_q  <= '0;
      b_q  <= '0;
      fa_q <= '0;
      fb_q <= '0;
    end else begin
      v_q <= in_valid;
      if (en) begin
        a_q  <= a_d;
        b_q  <= b_d;
        fa_q <= fa_d;
        fb_q <= fb_d;
      end
    end
  end
endmodule

// File: rtl/blend_mul.sv
module blend_mul
  import pix_blend_pkg::*;
#(
  parameter int LANES = PB_LANES,
  parameter int CH_W  = PB_CH_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     v_in,
  input  logic [LANES*2*CH_W-1:0]  a_in,
  input  logic [LANES*2*CH_W-1:0]  b_in,
  input  logic [LANES*2*CH_W-1:0]  fa_in,
  input  logic [LANES*2*CH_W-1:0]  fb_in,
  output logic                     v_q,
  output logic [LANES*2*CH_W-1:0]  pa_q,
  output logic [LANES*2*CH_W-1:0]  pb_q
);
  localparam int LW = 2 * CH_W;
  localparam logic [LW-1:0] ONE = LW'(1) << CH_W;

  logic [LANES*LW-1:0] pa_d, pb_d;
  logic                en;

  assign en = v_in;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      pa_d[i*LW +: LW] = a_in[i*LW +: LW] * fa_in[i*LW +: LW];
      pb_d[i*LW +: LW] = b_in[i*LW +: LW] * fb_in[i*LW +: LW];
    end

    // R3
    fac_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_in |-> (fa_in[i*LW +: LW] <= ONE && fb_in[i*LW +: LW] <= ONE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      pa_q <= '0;
      pb_q <= '0;
    end else begin
      v_q <= v_in;
      if (en) begin
        pa_q <= pa_d;
        pb_q <= pb_d;
      end
    end
  end
endmodule

// File: rtl/blend_pack.sv
module blend_pack
  import pix_blend_pkg::*;
#(
  parameter int LANES = PB_LANES,
  parameter int CH_W  = PB_CH_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     v_in,
  input  logic [LANES*2*CH_W-1:0]  pa_in,
  input  logic [LANES*2*CH_W-1:0]  pb_in,
  output logic                     v_q,
  output logic [LANES*CH_W-1:0]    pix_q
);
  localparam int LW = 2 * CH_W;

  logic [LANES*CH_W-1:0] pix_d;
  logic                  en;

  assign en = v_in;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LW:0] sum;
    logic [LW:0] sh;
    assign sum = {1'b0, pa_in[i*LW +: LW]} + {1'b0, pb_in[i*LW +: LW]};
    assign sh  = sum >> CH_W;

    always_comb begin
      if (|sh[LW:CH_W]) pix_d[i*CH_W +: CH_W] = '1;
      else              pix_d[i*CH_W +: CH_W] = sh[CH_W-1:0];
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_in |-> !sum[LW]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      pix_q <= '0;
    end else begin
      v_q <= v_in;
      if (en) pix_q <= pix_d;
    end
  end

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v_in |=> $stable(pix_q));
endmodule

// File: rtl/pix_blend_top.sv
module pix_blend_top
  import pix_blend_pkg::*;
#(
  parameter int LANES = PB_LANES,
  parameter int CH_W  = PB_CH_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [LANES*CH_W-1:0]  in_pix_a,
  input  logic [LANES*CH_W-1:0]  in_pix_b,
  input  logic [LANES*CH_W-1:0]  in_factor,
  output logic                   out_valid,
  output logic [LANES*CH_W-1:0]  out_pix
);
  localparam int LW = 2 * CH_W;

  logic [1:0] rst_sync_q, rst_sync_d;
  logic       rst_q;
  logic [1:0] age_q, age_d;

  assign rst_sync_d = {rst_sync_q[0], 1'b1};
  assign rst_q      = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= rst_sync_d;
  end

  logic                v1, v2;
  logic [LANES*LW-1:0] a1, b1, fa1, fb1, pa2, pb2;

  blend_expand #(.LANES(LANES), .CH_W(CH_W)) u_expand (
    .clk(clk), .rst_n(rst_q), .in_valid(in_valid),
    .pix_a(in_pix_a), .pix_b(in_pix_b), .factor(in_factor),
    .v_q(v1), .a_q(a1), .b_q(b1), .fa_q(fa1), .fb_q(fb1)
  );

  blend_mul #(.LANES(LANES), .CH_W(CH_W)) u_mul (
    .clk(clk), .rst_n(rst_q), .v_in(v1),
    .a_in(a1), .b_in(b1), .fa_in(fa1), .fb_in(fb1),
    .v_q(v2), .pa_q(pa2), .pb_q(pb2)
  );

  blend_pack #(.LANES(LANES), .CH_W(CH_W)) u_pack (
    .clk(clk), .rst_n(rst_q), .v_in(v2),
    .pa_in(pa2), .pb_in(pb2),
    .v_q(out_valid), .pix_q(out_pix)
  );

  assign age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) age_q <= 2'd0;
    else        age_q <= age_d;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R1
  reset_out_chk: assert property (@(posedge clk)
    !rst_q |-> (!out_valid && out_pix == '0));
endmodule

// File: tb/pix_blend_top_tb.sv
module pix_blend_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_pix_a = '0, in_pix_b = '0, in_factor = '0;
  logic        out_valid;
  logic [31:0] out_pix;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic        hv [4];
  logic [31:0] hp [4];
  string       ht [4];
  logic [31:0] last_exp = '0;

  always #10 clk = ~clk;

  pix_blend_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_pix_a(in_pix_a), .in_pix_b(in_pix_b), .in_factor(in_factor),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  function automatic logic [31:0] blend(input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] f);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      int fa, fe, av, bv, s;
      fa = int'(f[i*8 +: 8]);
      fe = fa + (fa >> 7);
      av = int'(a[i*8 +: 8]);
      bv = int'(b[i*8 +: 8]);
      s  = (av * fe + bv * (256 - fe)) >> 8;
      if (s > 255) s = 255;
      r[i*8 +: 8] = 8'(s);
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] f, input string tag);
    int slot;
    @(negedge clk);
    slot = (cyc + 1) % 4;
    chk("R2 out_valid", {31'b0, out_valid}, {31'b0, hv[slot]});
    if (hv[slot]) begin
      chk(ht[slot], out_pix, hp[slot]);
      last_exp = hp[slot];
    end else begin
      chk("R8 hold", out_pix, last_exp);
    end
    in_valid  = v;
    in_pix_a  = a;
    in_pix_b  = b;
    in_factor = f;
    hv[cyc % 4] = v;
    hp[cyc % 4] = blend(a, b, f);
    ht[cyc % 4] = tag;
    cyc++;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) begin hv[i] = 1'b0; hp[i] = '0; ht[i] = ""; end
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'b0, out_valid}, 32'd0);
    chk("R1 reset pix", out_pix, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 post-reset valid", {31'b0, out_valid}, 32'd0);
    chk("R1 post-reset pix", out_pix, 32'd0);

    step(1, 32'h12345678, 32'h9ABCDEF0, 32'hFFFFFFFF, "R5 full weight");
    step(1, 32'hA5C3_0F81, 32'h1122_3344, 32'h0000_0000, "R6 zero weight");
    step(1, 32'h7F7F_7F7F, 32'h0000_0000, 32'h7F7F_7F7F, "R3 weight 7F");
    step(1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h8080_8080, "R3 weight 80");
    step(1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0001_7F80, "R3 low weights");
    step(1, 32'hC8_64_32_10, 32'h10_32_64_C8, 32'h00_FF_80_7F, "R4 mixed lanes");
    step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h5A3C_A5C3, "R7 full scale");
    step(1, 32'hFF00_FF00, 32'h00FF_00FF, 32'hFF00_00FF, "R5 R6 per-lane mix");
    step(0, 32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h1234_5678, "R8 idle");
    step(0, 32'h0BAD_F00D, 32'hFEED_FACE, 32'hFFFF_FFFF, "R8 idle");
    step(0, 32'h1111_1111, 32'h2222_2222, 32'h0000_0000, "R8 idle");
    step(0, 32'h3333_3333, 32'h4444_4444, 32'h8080_8080, "R8 idle");

    for (int n = 0; n < 300; n++)
      step(1, $urandom, $urandom, $urandom, "R4 random burst");
    for (int n = 0; n < 300; n++)
      step(($urandom % 3) != 0, $urandom, $urandom, $urandom, "R2 gapped random");
    for (int n = 0; n < 6; n++)
      step(0, $urandom, $urandom, $urandom, "R8 drain");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule